// File: doc/BRIEF.md
# Multiplexed Microcontroller Bus Interface

This block is the host-facing front end of a memory peripheral attached to an 8051-style processor bus. On that bus the low eight address bits and the data byte share the same pins. A separate group of five pins carries the upper address bits. The block latches the full 13-bit address under the address-latch strobe. It then works out what the host is asking for from chip enable, program-store enable, read and write: an instruction fetch, a data read, a byte write, standby, or nothing at all. It enables the data-bus drivers only while one of the two read kinds is in progress.

The two read strobes differ only in which processor address space they come from. Both reach the same storage, so one device can hold code and data together. When the write strobe rises at the end of a write, the block hands the write engine a one-cycle pulse carrying the byte and the latched address. Every bus input arrives asynchronously and passes through a two-flop synchroniser into the system clock domain before any decoding or edge detection. The storage array and the programming timing are outside this block.

Top module: `muxbus_host_if`

## Requirements
- R1: While the synchronised address-latch strobe is high, `addr_o` equals {`hi_addr_i`, `ad_i`} as seen through the synchronisers, two clocks after the pins change.
- R2: Once the latch strobe has fallen, `addr_o` keeps the last value that was passed through, whatever the shared bus or the upper address pins do.
- R3: With chip enable high (`ce_n_i`=1) and the latch strobe low, `mode_o` is 1 (standby) and `ad_oe_o` is 0.
- R4: `ce_n_i`=0, `pstore_n_i`=0, `rd_n_i`=1 and `wr_n_i`=1 give `mode_o`=2 (program fetch), `ad_oe_o`=1 and `ad_o`=`rd_data_i`.
- R5: `ce_n_i`=0, `pstore_n_i`=1, `rd_n_i`=0 and `wr_n_i`=1 give `mode_o`=3 (data read), `ad_oe_o`=1 and `ad_o`=`rd_data_i`.
- R6: `ce_n_i`=0, `pstore_n_i`=1, `rd_n_i`=1 and `wr_n_i`=0 give `mode_o`=4 (write), and `ad_oe_o` is 0 so the bus is an input.
- R7: When the write strobe rises after the write mode, `wr_stb_o` is high for exactly one clock, three clocks after the pin edge. `wr_data_o` then carries the last bus byte sampled while the strobe was low, and `wr_addr_o` carries the latched address.
- R8: Every other strobe combination with chip enable low, and chip enable high with the latch strobe high, give `mode_o`=0 (idle) with `ad_oe_o`=0 and `ad_o`=0.
- R9: A write-strobe rise that does not follow the write mode (for example, from a combination where read and write are both low) produces no `wr_stb_o` pulse.
- R10: After reset, `mode_o` is 1 (standby), `ad_oe_o` and `wr_stb_o` are 0, and `addr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale_i | input | 1 | Address-latch strobe, active high |
| ce_n_i | input | 1 | Chip enable, active low |
| pstore_n_i | input | 1 | Program-store read strobe, active low |
| rd_n_i | input | 1 | Data read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| ad_i | input | 8 | Shared address/data bus, input side |
| hi_addr_i | input | 5 | Upper address pins |
| rd_data_i | input | 8 | Read byte from the storage array |
| ad_o | output | 8 | Shared bus, output side (0 when not driving) |
| ad_oe_o | output | 1 | Drive enable for the shared bus |
| addr_o | output | 13 | Current (transparent or latched) address |
| mode_o | output | 3 | 0 idle, 1 standby, 2 fetch, 3 data read, 4 write |
| wr_stb_o | output | 1 | One-cycle pulse handing a byte to the write engine |
| wr_data_o | output | 8 | Byte being written |
| wr_addr_o | output | 13 | Address of the byte being written |

## Verification
All pins pass through two synchroniser flops. `addr_o`, `mode_o`, `ad_oe_o` and `ad_o` therefore follow a pin change after the second rising edge, and `wr_stb_o` with its data and address follows one register later, after the third edge. The bench changes pins on a falling edge, waits three rising edges and samples on the next falling edge. The one-cycle width of the write pulse is checked one clock later. In the random phase the bench works out from each pair of successive strobe patterns whether a write pulse is due, and it compares the pulse count with that prediction.

// File: rtl/mbi_pkg.sv
package mbi_pkg;
  typedef enum logic [2:0] {
    MD_IDLE    = 3'd0,
    MD_STANDBY = 3'd1,
    MD_FETCH   = 3'd2,
    MD_DREAD   = 3'd3,
    MD_WRITE   = 3'd4
  } mbi_mode_e;
endpackage

// File: rtl/mbi_sync.sv
module mbi_sync #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q;
    logic sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[i];
        sync_q <= RST_VAL[i];
      end else begin
        meta_q <= d[i];
        sync_q <= meta_q;
      end
    end
    assign q[i] = sync_q;
  end
endmodule

// File: rtl/mbi_addr_latch.sv
module mbi_addr_latch #(
  parameter int LO_W = 8,
  parameter int HI_W = 5,
  localparam int AW  = LO_W + HI_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ale,
  input  logic [LO_W-1:0] lo,
  input  logic [HI_W-1:0] hi,
  output logic [AW-1:0]   addr
);
  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_d;

  always_comb begin
    addr_d = addr_q;
    if (ale) addr_d = {hi, lo};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else if (ale) addr_q <= addr_d;
  end

  assign addr = addr_d;
endmodule

// File: rtl/mbi_mode_dec.sv
module mbi_mode_dec
  import mbi_pkg::*;
(
  input  logic      ce_n,
  input  logic      ale,
  input  logic      ps_n,
  input  logic      rd_n,
  input  logic      wr_n,
  output mbi_mode_e mode,
  output logic      drive
);
  always_comb begin
    mode = MD_IDLE;
    if (ce_n) begin
      if (!ale) mode = MD_STANDBY;
    end else begin
      unique case ({ps_n, rd_n, wr_n})
        3'b011:  mode = MD_FETCH;
        3'b101:  mode = MD_DREAD;
        3'b110:  mode = MD_WRITE;
        default: mode = MD_IDLE;
      endcase
    end
    drive = !ce_n && (mode == MD_FETCH || mode == MD_DREAD);
  end
endmodule

// File: rtl/mbi_wr_cap.sv
module mbi_wr_cap
  import mbi_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  mbi_mode_e     mode,
  input  logic          wr_n,
  input  logic [DW-1:0] bus,
  input  logic [AW-1:0] addr,
  output logic          stb,
  output logic [DW-1:0] data,
  output logic [AW-1:0] waddr
);
  logic          was_wr_q;
  logic [DW-1:0] hold_q, hold_d;
  logic          stb_q, stb_d;
  logic [DW-1:0] data_q, data_d;
  logic [AW-1:0] waddr_q, waddr_d;
  logic          rise;

  always_comb begin
    rise    = was_wr_q && wr_n;
    hold_d  = (mode == MD_WRITE) ? bus : hold_q;
    stb_d   = rise;
    data_d  = rise ? hold_q : data_q;
    waddr_d = rise ? addr : waddr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      was_wr_q <= 1'b0;
      hold_q   <= '0;
      stb_q    <= 1'b0;
      data_q   <= '0;
      waddr_q  <= '0;
    end else begin
      was_wr_q <= (mode == MD_WRITE);
      hold_q   <= hold_d;
      stb_q    <= stb_d;
      if (rise) begin
        data_q  <= data_d;
        waddr_q <= waddr_d;
      end
    end
  end

  assign stb   = stb_q;
  assign data  = data_q;
  assign waddr = waddr_q;
endmodule

// File: rtl/muxbus_host_if.sv
module muxbus_host_if
  import mbi_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HI_W   = 5,
  localparam int ADDR_W = DATA_W + HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale_i,
  input  logic              ce_n_i,
  input  logic              pstore_n_i,
  input  logic              rd_n_i,
  input  logic              wr_n_i,
  input  logic [DATA_W-1:0] ad_i,
  input  logic [HI_W-1:0]   hi_addr_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [2:0]        mode_o,
  output logic              wr_stb_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [ADDR_W-1:0] wr_addr_o
);
  logic rst_m_q, rst_s_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  logic [4:0] ctl_s;
  logic       ale_s, ce_n_s, ps_n_s, rd_n_s, wr_n_s;
  mbi_sync #(.W(5), .RST_VAL(5'b11110)) u_ctl_sync (
    .clk(clk), .rst_n(rst_s_q),
    .d({ce_n_i, pstore_n_i, rd_n_i, wr_n_i, ale_i}),
    .q(ctl_s)
  );
  assign {ce_n_s, ps_n_s, rd_n_s, wr_n_s, ale_s} = ctl_s;

  logic [ADDR_W-1:0] bus_s;
  mbi_sync #(.W(ADDR_W), .RST_VAL('0)) u_bus_sync (
    .clk(clk), .rst_n(rst_s_q),
    .d({hi_addr_i, ad_i}),
    .q(bus_s)
  );

  mbi_addr_latch #(.LO_W(DATA_W), .HI_W(HI_W)) u_latch (
    .clk(clk), .rst_n(rst_s_q), .ale(ale_s),
    .lo(bus_s[DATA_W-1:0]), .hi(bus_s[ADDR_W-1:DATA_W]),
    .addr(addr_o)
  );

  mbi_mode_e mode;
  logic      drive;
  mbi_mode_dec u_dec (
    .ce_n(ce_n_s), .ale(ale_s), .ps_n(ps_n_s), .rd_n(rd_n_s), .wr_n(wr_n_s),
    .mode(mode), .drive(drive)
  );

  mbi_wr_cap #(.DW(DATA_W), .AW(ADDR_W)) u_wr (
    .clk(clk), .rst_n(rst_s_q), .mode(mode), .wr_n(wr_n_s),
    .bus(bus_s[DATA_W-1:0]), .addr(addr_o),
    .stb(wr_stb_o), .data(wr_data_o), .waddr(wr_addr_o)
  );

  assign mode_o  = mode;
  assign ad_oe_o = drive;
  assign ad_o    = drive ? rd_data_i : '0;
endmodule

// File: rtl/mbi_checker.sv
module mbi_checker
  import mbi_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ale_s,
  input logic [2:0]    mode,
  input logic          oe,
  input logic [DW-1:0] ad_o,
  input logic [DW-1:0] rd_data,
  input logic          stb,
  input logic [AW-1:0] addr
);
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale_s && $past(!ale_s)) |-> $stable(addr)) else $error("addr moved"); // R2
  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'(MD_STANDBY)) |-> !oe) else $error("standby drive"); // R3
  AST_DRIVE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> (ad_o == rd_data)) else $error("drive data"); // R4
  AST_DRIVE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> (mode == 3'(MD_FETCH) || mode == 3'(MD_DREAD))) else $error("drive mode"); // R5
  AST_WRITE_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'(MD_WRITE)) |-> !oe) else $error("write drive"); // R6
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> !stb) else $error("long pulse"); // R7
  AST_STB_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> ($past(mode, 2) == 3'(MD_WRITE))) else $error("pulse w/o write"); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'(MD_IDLE)) |-> (!oe && ad_o == '0)) else $error("idle drive"); // R8
endmodule

bind muxbus_host_if mbi_checker #(.DW(DATA_W), .AW(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ale_s(ale_s), .mode(mode_o), .oe(ad_oe_o),
  .ad_o(ad_o), .rd_data(rd_data_i), .stb(wr_stb_o), .addr(addr_o)
);

// File: tb/muxbus_host_if_bench.sv
`timescale 1ns/1ps
module muxbus_host_if_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ale, ce_n, ps_n, rd_n, wr_n;
  logic [7:0]  ad, rdd;
  logic [4:0]  hi;
  logic [7:0]  ad_o, wr_data;
  logic        oe, stb;
  logic [12:0] addr, wr_addr;
  logic [2:0]  mode;

  int tests = 0, fails = 0, pulses = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  muxbus_host_if u_muxbus_host_if (
    .clk(clk), .rst_n(rst_n), .ale_i(ale), .ce_n_i(ce_n), .pstore_n_i(ps_n),
    .rd_n_i(rd_n), .wr_n_i(wr_n), .ad_i(ad), .hi_addr_i(hi), .rd_data_i(rdd),
    .ad_o(ad_o), .ad_oe_o(oe), .addr_o(addr), .mode_o(mode),
    .wr_stb_o(stb), .wr_data_o(wr_data), .wr_addr_o(wr_addr)
  );

  always @(negedge clk) if (stb) pulses++;

  function automatic logic [2:0] exp_mode(logic c, logic a, logic p, logic r, logic w);
    if (c) return a ? 3'd0 : 3'd1;
    case ({p, r, w})
      3'b011:  return 3'd2;
      3'b101:  return 3'd3;
      3'b110:  return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(logic c, logic a, logic p, logic r, logic w);
    ce_n = c; ale = a; ps_n = p; rd_n = r; wr_n = w;
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [2:0] pm, em;
    int base, expp;
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    drive(1, 0, 1, 1, 1); ad = 8'h00; hi = 5'h00; rdd = 8'h5A;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 mode", mode, 3'd1);
    chk("R10 oe", oe, 0);
    chk("R10 stb", stb, 0);
    chk("R10 addr", addr, 13'h0);

    // address latch
    drive(1, 1, 1, 1, 1); ad = 8'hA5; hi = 5'h13;
    settle();
    chk("R1 pass-through", addr, {5'h13, 8'hA5});
    chk("R8 ce high ale high idle", mode, 3'd0);
    ale = 1'b0;
    settle();
    ad = 8'h3C; hi = 5'h04;
    settle();
    chk("R2 hold", addr, {5'h13, 8'hA5});
    chk("R3 standby", mode, 3'd1);
    chk("R3 tristate", oe, 0);

    // reads
    rdd = 8'hC7; drive(0, 0, 0, 1, 1);
    settle();
    chk("R4 mode", mode, 3'd2);
    chk("R4 oe", oe, 1);
    chk("R4 data", ad_o, 8'hC7);
    drive(0, 0, 1, 0, 1); rdd = 8'h19;
    settle();
    chk("R5 mode", mode, 3'd3);
    chk("R5 data", ad_o, 8'h19);

    // write
    drive(0, 0, 1, 1, 1);
    settle();
    base = pulses;
    drive(0, 0, 1, 1, 0); ad = 8'h61;
    settle();
    chk("R6 mode", mode, 3'd4);
    chk("R6 input", oe, 0);
    ad = 8'h9E;
    settle();
    wr_n = 1'b1; ad = 8'hEE;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R7 not early", stb, 0);
    @(posedge clk); @(negedge clk);
    chk("R7 pulse", stb, 1);
    chk("R7 data", wr_data, 8'h9E);
    chk("R7 addr", wr_addr, {5'h13, 8'hA5});
    @(negedge clk);
    chk("R7 width", stb, 0);

    // rise without write mode
    drive(0, 0, 1, 0, 0);
    settle();
    chk("R8 rd+wr idle", mode, 3'd0);
    chk("R8 idle bus", ad_o, 8'h00);
    base = pulses;
    wr_n = 1'b1;
    settle(); settle();
    chk("R9 no pulse", pulses - base, 0);

    // random phase
    drive(1, 0, 1, 1, 1);
    settle();
    pm = 3'd1; pulses = 0; expp = 0;
    for (int i = 0; i < 400; i++) begin
      logic [4:0] r;
      logic [12:0] a;
      r = 5'($urandom);
      a = 13'($urandom);
      rdd = 8'($urandom);
      ad = a[7:0]; hi = a[12:8];
      drive(r[0], r[1] & r[4], r[2], r[3], $urandom_range(0, 1) == 1);
      em = exp_mode(ce_n, ale, ps_n, rd_n, wr_n);
      if (pm == 3'd4 && wr_n) expp++;
      settle();
      chk("R8 random mode", mode, em);
      chk("R5 random oe", oe, (em == 3'd2 || em == 3'd3));
      if (em == 3'd2 || em == 3'd3) chk("R4 random data", ad_o, rdd);
      if (ale) chk("R1 random addr", addr, a);
      pm = em;
    end
    drive(1, 0, 1, 1, 1);
    if (pm == 3'd4) expp++;
    settle(); settle();
    chk("R7 random pulse count", pulses, expp);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule